// File: doc/BRIEF.md
# Permission-Checked Translation Cache

This block is a small, fully associative cache of address translations. It sits in front of a page-table walker. Each request carries a virtual address, an access kind (read or write) and a privilege level (user or system). The virtual page number is compared against every valid entry at once. The result comes back on the registered outputs one cycle after the request. A hit returns the physical address. A miss tells the walker to fetch the translation. A fault reports an access that the cached permission bits forbid.

Each entry stores a virtual page number, a physical frame number and three attribute bits: read-only, system-only and dirty. The walker installs translations through a refill port. A refill replaces the lowest-numbered free entry, or, when all entries are in use, the entry chosen by a round-robin pointer. The first permitted write to a clean page marks the entry dirty. It also raises a one-cycle pulse so that the walker can write the dirty state back to the page table. A flush input empties the whole cache in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: A request whose virtual page number matches a valid entry, with no permission violation, raises rsp_hit exactly one cycle later. In that cycle rsp_paddr = {frame number, page offset}.
- R2: A request whose page number matches no valid entry raises rsp_miss one cycle later. In that cycle rsp_vpn holds the requested page number and rsp_paddr is zero.
- R3: rsp_hit, rsp_miss and rsp_fault are never high together. All of them and rsp_dirty_upd are low after reset and in any cycle that follows a cycle without req_valid.
- R4: A write (req_write=1) that hits an entry with the read-only attribute set gives rsp_fault instead of rsp_hit, with rsp_paddr zero. A read of the same entry hits.
- R5: A user access (req_user=1) that hits an entry with the system-only attribute set gives rsp_fault. A system access (req_user=0) is allowed on every entry.
- R6: A permitted write hit on an entry whose dirty attribute is clear sets that attribute and raises rsp_dirty_upd together with rsp_hit. Later writes, reads and faulting writes to the same entry do not pulse rsp_dirty_upd.
- R7: The low OFF_W (12) bits of the virtual address pass through untranslated into the low bits of rsp_paddr.
- R8: A refill with no flush in the same cycle installs the translation at the clock edge. A refill goes into the lowest-numbered invalid entry when one exists.
- R9: When all entries are valid, a refill of a new page number replaces the entry at a round-robin pointer. The pointer is 0 after reset, advances by one after each such replacement, and wraps from ENTRIES-1 to 0.
- R10: A refill whose page number is already cached overwrites that entry in place. It evicts nothing and leaves the round-robin pointer unchanged.
- R11: A flush clears every entry in one cycle. A refill in the same cycle as a flush is dropped.
- R12: A request in the same cycle as a refill or a flush is looked up against the contents held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VPN_W+OFF_W | Virtual address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user level, 0 = system level |
| refill_valid | input | 1 | Install a translation from the walker |
| refill_vpn | input | VPN_W | Virtual page number to install |
| refill_pfn | input | PFN_W | Physical frame number to install |
| refill_ro | input | 1 | Read-only attribute of the installed page |
| refill_sys | input | 1 | System-only attribute of the installed page |
| refill_dirty | input | 1 | Initial dirty attribute of the installed page |
| flush | input | 1 | Invalidate every entry |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No translation cached; a walk is needed |
| rsp_fault | output | 1 | Translation found but the access is forbidden |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, zero otherwise |
| rsp_vpn | output | VPN_W | Page number of the last request |
| rsp_dirty_upd | output | 1 | Entry just became dirty; write back to the page table |

## Verification
The bound checker watches, on every cycle, the properties that concern only the response outputs:
- the three outcome flags are mutually exclusive, and none of them follows an idle cycle;
- the page offset passes through on a hit, and the address is zero on a fault or miss;
- a dirty pulse comes only with a write hit;
- a request right after a flush always misses.

The bench scenarios cover the properties that depend on the stored contents:
- which entry a refill replaces, round-robin order and in-place overwrite;
- the full matrix of attribute and access combinations;
- dirty marking that fires only once per entry;
- refills dropped under a flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Attribute bits kept with every cached translation
  typedef struct packed {
    logic ro;     // writes forbidden
    logic sys;    // user-level access forbidden
    logic dirty;  // page already written
  } xlat_attr_t;

endpackage

// File: rtl/xlat_cam.sv
// Parallel tag compare over all entries, with a binary encode of the match
module xlat_cam #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);

  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  assign any_o = |match;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
// Chooses the entry a new translation goes into: lowest free slot first,
// otherwise a round-robin pointer over all slots
module xlat_victim #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  input  logic             advance_i,
  output logic             full_o,
  output logic [IDX_W-1:0] victim_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign full_o   = &valid_i;
  assign victim_o = full_o ? ptr_q : free_idx;

  always_comb begin
    ptr_d = ptr_q;
    if (advance_i) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (advance_i) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/xlat_check.sv
// Permission check of a hit entry against the access kind and level
module xlat_check
  import xlat_pkg::*;
(
  input  xlat_attr_t attr_i,
  input  logic       write_i,
  input  logic       user_i,
  output logic       fault_o,
  output logic       mark_dirty_o
);

  logic wr_blocked;
  logic lvl_blocked;

  assign wr_blocked   = write_i && attr_i.ro;
  assign lvl_blocked  = user_i && attr_i.sys;
  assign fault_o      = wr_blocked || lvl_blocked;
  assign mark_dirty_o = write_i && !fault_o && !attr_i.dirty;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  input  logic                   refill_valid,
  input  logic [VPN_W-1:0]       refill_vpn,
  input  logic [PFN_W-1:0]       refill_pfn,
  input  logic                   refill_ro,
  input  logic                   refill_sys,
  input  logic                   refill_dirty,
  input  logic                   flush,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_fault,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [VPN_W-1:0]       rsp_vpn,
  output logic                   rsp_dirty_upd
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  // ---------------- entry storage ----------------
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q, vpn_d;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q, pfn_d;
  xlat_attr_t [ENTRIES-1:0]      attr_q, attr_d;
  logic                          tbl_we;

  // ---------------- lookup path ----------------
  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  logic             look_any;
  logic [IDX_W-1:0] look_idx;
  logic             look_fault;
  logic             look_mark;

  assign look_vpn = req_vaddr[VA_W-1:OFF_W];
  assign look_off = req_vaddr[OFF_W-1:0];

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_look_cam (
    .valid_i (valid_q),
    .tags_i  (vpn_q),
    .key_i   (look_vpn),
    .any_o   (look_any),
    .idx_o   (look_idx)
  );

  xlat_check u_check (
    .attr_i       (attr_q[look_idx]),
    .write_i      (req_write),
    .user_i       (req_user),
    .fault_o      (look_fault),
    .mark_dirty_o (look_mark)
  );

  // ---------------- refill path ----------------
  logic             fill_take;
  logic             fill_any;
  logic [IDX_W-1:0] fill_idx;
  logic             tbl_full;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] fill_slot;
  logic             rr_advance;

  assign fill_take = refill_valid && !flush;

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_fill_cam (
    .valid_i (valid_q),
    .tags_i  (vpn_q),
    .key_i   (refill_vpn),
    .any_o   (fill_any),
    .idx_o   (fill_idx)
  );

  assign rr_advance = fill_take && !fill_any && tbl_full;

  xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_q),
    .advance_i (rr_advance),
    .full_o    (tbl_full),
    .victim_o  (victim_idx)
  );

  assign fill_slot = fill_any ? fill_idx : victim_idx;

  // ---------------- table next state ----------------
  logic set_dirty;

  assign set_dirty = req_valid && look_any && look_mark;

  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    pfn_d   = pfn_q;
    attr_d  = attr_q;
    if (set_dirty) attr_d[look_idx].dirty = 1'b1;
    if (fill_take) begin
      valid_d[fill_slot]      = 1'b1;
      vpn_d[fill_slot]        = refill_vpn;
      pfn_d[fill_slot]        = refill_pfn;
      attr_d[fill_slot].ro    = refill_ro;
      attr_d[fill_slot].sys   = refill_sys;
      attr_d[fill_slot].dirty = refill_dirty;
    end
    if (flush) valid_d = '0;
  end

  assign tbl_we = set_dirty || fill_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 valid_q <= '0;
    else if (tbl_we || flush)   valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      vpn_q  <= vpn_d;
      pfn_q  <= pfn_d;
      attr_q <= attr_d;
    end
  end

  // ---------------- response next state ----------------
  logic            hit_d, miss_d, fault_d, dupd_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    hit_d   = req_valid && look_any && !look_fault;
    miss_d  = req_valid && !look_any;
    fault_d = req_valid && look_any && look_fault;
    dupd_d  = set_dirty;
    paddr_d = hit_d ? {pfn_q[look_idx], look_off} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit       <= 1'b0;
      rsp_miss      <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_dirty_upd <= 1'b0;
      rsp_paddr     <= '0;
    end else begin
      rsp_hit       <= hit_d;
      rsp_miss      <= miss_d;
      rsp_fault     <= fault_d;
      rsp_dirty_upd <= dupd_d;
      rsp_paddr     <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_vpn <= '0;
    else if (req_valid) rsp_vpn <= look_vpn;
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   req_write,
  input logic                   flush,
  input logic                   rsp_hit,
  input logic                   rsp_miss,
  input logic                   rsp_fault,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic [VPN_W-1:0]       rsp_vpn,
  input logic                   rsp_dirty_upd
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_fault}));

  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !$past(req_valid) |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_dirty_upd));

  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_valid) |-> (rsp_hit || rsp_miss || rsp_fault));

  a_r7_offset_passes: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  a_r4_no_addr_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0);

  a_r2_miss_reports_vpn: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    rsp_miss |-> rsp_vpn == $past(req_vaddr[VPN_W+OFF_W-1:OFF_W]));

  a_r6_dirty_with_write_hit: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    rsp_dirty_upd |-> (rsp_hit && $past(req_write)));

  a_r11_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (req_valid && $past(flush)) |=> rsp_miss);

endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W (VPN_W),
  .PFN_W (PFN_W),
  .OFF_W (OFF_W)
) u_xlat_cache_chk (.*);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int OFF_W = 12;
  localparam int N     = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_user;
  logic [VPN_W+OFF_W-1:0] req_vaddr;
  logic refill_valid, refill_ro, refill_sys, refill_dirty, flush;
  logic [VPN_W-1:0] refill_vpn;
  logic [PFN_W-1:0] refill_pfn;
  logic rsp_hit, rsp_miss, rsp_fault, rsp_dirty_upd;
  logic [PFN_W+OFF_W-1:0] rsp_paddr;
  logic [VPN_W-1:0] rsp_vpn;

  int n_run  = 0;
  int n_fail = 0;

  // reference model
  bit mval[N];
  int mvpn[N];
  int mpfn[N];
  bit mro[N], msys[N], mdirty[N];
  int mptr;

  always #4 clk = ~clk;

  xlat_cache #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ENTRIES(N)) i_xlat_cache (
    .clk, .rst_n, .req_valid, .req_vaddr, .req_write, .req_user,
    .refill_valid, .refill_vpn, .refill_pfn, .refill_ro, .refill_sys, .refill_dirty,
    .flush, .rsp_hit, .rsp_miss, .rsp_fault, .rsp_paddr, .rsp_vpn, .rsp_dirty_upd
  );

  function automatic int find(input int vpn);
    for (int i = 0; i < N; i++) if (mval[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One cycle of stimulus, then compare the registered response
  task automatic op(input bit dq, input int vpn, input int off, input bit w, input bit u,
                    input bit df, input int fvpn, input int fpfn, input bit fro,
                    input bit fsys, input bit fdirty, input bit dfl, input string tag);
    int idx, slot;
    bit e_hit, e_miss, e_fault, e_dupd;
    logic [PFN_W+OFF_W-1:0] e_pa;
    string t;
    @(negedge clk);
    req_valid = dq; req_vaddr = {VPN_W'(vpn), OFF_W'(off)}; req_write = w; req_user = u;
    refill_valid = df; refill_vpn = VPN_W'(fvpn); refill_pfn = PFN_W'(fpfn);
    refill_ro = fro; refill_sys = fsys; refill_dirty = fdirty; flush = dfl;
    // expectation from contents before the edge
    idx = find(vpn);
    e_hit = 0; e_miss = 0; e_fault = 0; e_dupd = 0; e_pa = '0;
    t = tag;
    if (dq) begin
      if (idx < 0) e_miss = 1;
      else if ((w && mro[idx]) || (u && msys[idx])) begin
        e_fault = 1;
        if (tag == "") t = (w && mro[idx]) ? "R4" : "R5";
      end else begin
        e_hit = 1;
        e_pa = {PFN_W'(mpfn[idx]), OFF_W'(off)};
        if (w && !mdirty[idx]) begin e_dupd = 1; mdirty[idx] = 1; if (tag == "") t = "R6"; end
      end
      if (t == "") t = e_miss ? "R2" : "R1 R7";
    end else if (t == "") t = "R3";
    // model updates in the design's order
    if (df && !dfl) begin
      slot = find(fvpn);
      if (slot < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!mval[i]) slot = i;
        if (slot < 0) begin slot = mptr; mptr = (mptr + 1) % N; end
      end
      mval[slot] = 1; mvpn[slot] = fvpn; mpfn[slot] = fpfn;
      mro[slot] = fro; msys[slot] = fsys; mdirty[slot] = fdirty;
    end
    if (dfl) for (int i = 0; i < N; i++) mval[i] = 0;
    @(negedge clk);
    req_valid = 0; refill_valid = 0; flush = 0;
    check(t, {28'd0, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_upd, rsp_paddr},
             {28'd0, e_hit, e_miss, e_fault, e_dupd, e_pa});
    if (dq && e_miss) check("R2", 64'(rsp_vpn), 64'(VPN_W'(vpn)));
  endtask

  task automatic look(input int vpn, input int off, input bit w, input bit u, input string tag);
    op(1, vpn, off, w, u, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input int vpn, input int pfn, input bit ro, input bit sys, input bit d);
    op(0, 0, 0, 0, 0, 1, vpn, pfn, ro, sys, d, 0, "R3");
  endtask

  task automatic look_all(input string tag);
    for (int i = 0; i < N; i++) if (mval[i]) look(mvpn[i], (i * 291) & 12'hfff, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mval[i] = 0; mdirty[i] = 0; end
    mptr = 0;
    rst_n = 0; req_valid = 0; req_vaddr = '0; req_write = 0; req_user = 0;
    refill_valid = 0; refill_vpn = '0; refill_pfn = '0; refill_ro = 0;
    refill_sys = 0; refill_dirty = 0; flush = 0;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3", {59'd0, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_upd, |rsp_paddr}, 64'd0);
    rst_n = 1;
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    look(5, 12'h123, 0, 0, "R2");

    // Exhaustive attribute x access matrix (R8 fills into free slots)
    for (int k = 0; k < N; k++) fill(16'h100 + k, 16'h500 + 3 * k, k[0], k[1], k[2]);
    look_all("R8");
    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < N; k++)
        for (int a = 0; a < 4; a++)
          look(16'h100 + k, (k * 517 + a * 33 + pass * 5) & 12'hfff, a[0], a[1], "");
    look(3, 12'hfff, 1, 1, "R2");

    // R9: round-robin replacement with all entries full
    for (int j = 0; j < 12; j++) begin
      fill(16'h200 + j, 16'h700 + j, 0, 0, 0);
      look_all("R9");
      if (j >= 1) look(16'h100 + ((j + 7) % 8), 0, 0, 0, "R9");
    end

    // R10: refill of a cached page overwrites in place
    fill(mvpn[2], 16'h9abc, 0, 1, 0);
    look_all("R10");
    look(mvpn[2], 12'h044, 0, 1, "R10");
    fill(16'h300, 16'h333, 0, 0, 0);
    look_all("R10");

    // R12: request alongside a refill sees old contents
    op(1, 16'h301, 12'h010, 0, 0, 1, 16'h301, 16'h444, 0, 0, 0, 0, "R12");
    look(16'h301, 12'h010, 0, 0, "R12");
    // R12: request alongside a flush still hits the old entry
    op(1, 16'h301, 12'h020, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R12");
    look(16'h301, 12'h020, 0, 0, "R11");

    // R11: flush drops a simultaneous refill
    for (int k = 0; k < N; k++) fill(16'h400 + k, 16'h600 + k, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 16'h4ff, 16'h1, 0, 0, 0, 1, "R11");
    look(16'h4ff, 0, 0, 0, "R11");
    for (int k = 0; k < N; k++) look(16'h400 + k, 0, 0, 0, "R11");

    // R8 / R9: refill after flush, then continue replacement order
    for (int k = 0; k < N + 3; k++) begin
      fill(16'h800 + k, 16'h880 + k, k[0], 0, 0);
      look_all("R9");
    end
    // R6: dirty-marked refill gives no pulse
    fill(16'h900, 16'h901, 0, 0, 1);
    look(16'h900, 12'h7, 1, 0, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule